// File: doc/BRIEF.md
# Serial Transmit Engine with Line-Break and Graceful Stop

This block turns parallel characters into an asynchronous serial stream on a single output line. A character is handed over with a valid/ready handshake. The block frames it as one low start bit, then the data bits with the least significant bit first, then one high stop bit. Each bit lasts exactly one period of an external baud tick. Baud-rate generation, queuing and parity belong to other blocks.

Two control inputs shape the line. The break input forces the line low at once, even partway through a character, and holds it low for as long as the input stays high. The stop input lets the character being sent run to its stop bit, then halts the transmitter. A sticky flag reports that the halt has taken effect. Software can therefore stop the engine, wait for the flag, and only then raise break without cutting a character short.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset the line is high, ready is 1, busy is 0 and the stop-done flag is 0.
- R2: A frame is a low start bit, DATA_W data bits with the LSB first, then a high stop bit. Each bit begins on a baud tick and lasts until the next tick. The line is high between frames.
- R3: A character is taken on a clock edge where valid and ready are both 1. While a frame is pending or being sent, busy is 1 and ready is 0.
- R4: While break is 1, the line is low in the same cycle, whatever the engine is doing, including partway through a frame.
- R5: The line stays low for every cycle that break stays 1. After break falls, the line shows the frame bit or the idle level again.
- R6: When stop is raised while a character is pending or in flight, that character is still sent complete, through its stop bit.
- R7: While stop is 1 and the engine is idle, ready is 0, valid is ignored, busy stays 0 and the line stays high.
- R8: The stop-done flag rises one clock after the engine becomes idle with stop at 1. It is never 1 while busy is 1.
- R9: The stop-done flag stays at 1 until a one-cycle clear pulse arrives or stop returns to 0. Either one drops it on the next edge. A clear pulse does not make the flag rise again while stop stays at 1.
- R10: If a clear pulse falls in the same cycle as the flag's rising event, the flag still becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse per bit period |
| valid_i | input | 1 | Character offered |
| data_i | input | DATA_W | Character to send (DATA_W is 7, 8 or 9) |
| brk_en_i | input | 1 | Force the line low while 1 |
| tx_stop_i | input | 1 | Halt after the current character |
| stop_clr_i | input | 1 | One-cycle clear of the stop-done flag |
| tx_o | output | 1 | Serial line |
| ready_o | output | 1 | Engine can take a character |
| busy_o | output | 1 | Frame pending or being sent |
| stop_done_o | output | 1 | Sticky flag: the engine has halted on request |

## Verification
Two events can fall in the same cycle: the stop-done flag rising when the engine reaches idle with stop held, and a software clear pulse. The bench provokes this by raising stop during a frame. It watches for the first cycle in which busy reads 0 and drives the clear pulse into that cycle. The check is that the flag reads 1 afterwards (R10). A second overlap is break against a frame in flight: break is raised partway through the data bits, and the bench requires the line to read low in that same cycle and in every cycle after it until break falls.

// File: rtl/uart_brk_tx_pkg.sv
package uart_brk_tx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARM   = 2'd1,  // character loaded, waiting for the first tick
    TX_SHIFT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/uart_brk_tx_shift.sv
module uart_brk_tx_shift
  import uart_brk_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bit_o,
  output logic              busy_o
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  tx_state_e          state_q;
  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      sr_q    <= '1;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (load_i) begin
          sr_q    <= {1'b1, data_i, 1'b0};
          state_q <= TX_ARM;
        end
        TX_ARM: if (tick_i) begin
          state_q <= TX_SHIFT;
          idx_q   <= '0;
        end
        TX_SHIFT: if (tick_i) begin
          if (idx_q == LAST) begin
            state_q <= TX_IDLE;
          end else begin
            sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign bit_o  = (state_q == TX_SHIFT) ? sr_q[0] : 1'b1;
  assign busy_o = (state_q != TX_IDLE);

  assert_bit_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_SHIFT && !tick_i) |=> (state_q == TX_SHIFT && $stable(bit_o)));
  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_ARM && tick_i) |=> !bit_o);
  assert_stop_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_SHIFT && idx_q == LAST) |-> bit_o);
endmodule

// File: rtl/uart_brk_tx_seq.sv
module uart_brk_tx_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic stop_req_i,
  input  logic valid_i,
  input  logic clr_i,
  output logic ready_o,
  output logic load_o,
  output logic done_o
);
  logic halted, halted_q, done_q, halt_evt;

  assign halted   = idle_i && stop_req_i;
  assign halt_evt = halted && !halted_q;
  assign ready_o  = idle_i && !stop_req_i;
  assign load_o   = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      halted_q <= halted;
      // the rising event outranks a clear in the same cycle
      if (halt_evt)                 done_q <= 1'b1;
      else if (clr_i || !stop_req_i) done_q <= 1'b0;
    end
  end

  assign done_o = done_q;

  assert_done_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_evt |=> done_q);
  assert_done_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_req_i |=> !done_q);
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              brk_en_i,
  input  logic              tx_stop_i,
  input  logic              stop_clr_i,
  output logic              tx_o,
  output logic              ready_o,
  output logic              busy_o,
  output logic              stop_done_o
);
  logic load, frame_bit, busy;

  uart_brk_tx_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idle_i     (!busy),
    .stop_req_i (tx_stop_i),
    .valid_i    (valid_i),
    .clr_i      (stop_clr_i),
    .ready_o    (ready_o),
    .load_o     (load),
    .done_o     (stop_done_o)
  );

  uart_brk_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (baud_tick_i),
    .load_i (load),
    .data_i (data_i),
    .bit_o  (frame_bit),
    .busy_o (busy)
  );

  // break overrides the line without disturbing the shifter
  assign tx_o   = brk_en_i ? 1'b0 : frame_bit;
  assign busy_o = busy;

  assert_ready_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ready_o);
  assert_hold_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_stop_i && !busy_o) |=> !busy_o);
  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_done_o |-> !busy_o);
endmodule

// File: tb/uart_brk_tx_tb.sv
module uart_brk_tx_tb;
  localparam int unsigned DW = 8;
  localparam int unsigned FW = DW + 2;
  localparam int unsigned WD = 100000;

  typedef struct packed {
    logic [DW-1:0] data;
    logic [FW-1:0] frame;  // frame[i] = i-th bit on the line
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'hA5, {1'b1, 8'hA5, 1'b0}},
    '{8'h00, {1'b1, 8'h00, 1'b0}},
    '{8'hFF, {1'b1, 8'hFF, 1'b0}},
    '{8'h01, {1'b1, 8'h01, 1'b0}},
    '{8'h80, {1'b1, 8'h80, 1'b0}},
    '{8'h3C, {1'b1, 8'h3C, 1'b0}}
  };

  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, valid = 1'b0;
  logic brk = 1'b0, stop = 1'b0, clr = 1'b0;
  logic [DW-1:0] data = '0;
  logic tx, ready, busy, done;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  uart_brk_tx #(.DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .baud_tick_i(tick), .valid_i(valid),
    .data_i(data), .brk_en_i(brk), .tx_stop_i(stop), .stop_clr_i(clr),
    .tx_o(tx), .ready_o(ready), .busy_o(busy), .stop_done_o(done)
  );

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      tick = (cnt == 3);
      cnt  = (cnt + 1) % 4;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [DW-1:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    valid = 1'b1; data = d;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic capture(output logic [FW-1:0] cap);
    int n = 0;
    cap = '0;
    while (tx !== 1'b0 && n < 200) begin @(negedge clk); n++; end
    for (int i = 0; i < FW; i++) begin
      cap[i] = tx;
      if (i < FW - 1) repeat (4) @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [FW-1:0] cap;
    int bad;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 tx", tx, 1); chk("R1 ready", ready, 1);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);

    // table of characters and expected line frames
    for (int v = 0; v < 6; v++) begin
      send(VEC[v].data);
      chk("R3 ready low after accept", ready, 0);
      chk("R3 busy after accept", busy, 1);
      capture(cap);
      chk("R2 frame", cap, VEC[v].frame);
      wait_idle();
    end
    chk("R2 idle high", tx, 1);

    // break partway through a character
    send(8'hFF);
    while (tx !== 1'b0) @(negedge clk);
    repeat (6) @(negedge clk);
    brk = 1'b1; #1;
    chk("R4 break immediate mid-frame", tx, 0);
    bad = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (tx !== 1'b0) bad++; end
    chk("R5 break held", bad, 0);
    brk = 1'b0; #1;
    chk("R5 line back after break", tx, 1);
    wait_idle();
    brk = 1'b1; #1;
    chk("R4 break while idle", tx, 0);
    @(negedge clk); brk = 1'b0; #1;
    chk("R5 idle after break", tx, 1);

    // stop raised mid-character
    send(8'h3C);
    fork
      capture(cap);
      begin repeat (10) @(negedge clk); stop = 1'b1; end
    join
    chk("R6 full frame despite stop", cap, {1'b1, 8'h3C, 1'b0});
    chk("R8 no flag while busy", done, 0);
    wait_idle();
    chk("R8 flag one cycle late", done, 0);
    @(negedge clk);
    chk("R8 flag raised", done, 1);
    chk("R7 ready low while stopped", ready, 0);

    valid = 1'b1; data = 8'h00;
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (tx !== 1'b1 || busy !== 1'b0 || ready !== 1'b0) bad++;
    end
    valid = 1'b0;
    chk("R7 valid ignored while stopped", bad, 0);
    chk("R9 flag sticky", done, 1);

    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R9 clear pulse", done, 0);
    repeat (3) @(negedge clk);
    chk("R9 stays clear while stopped", done, 0);

    stop = 1'b0; @(negedge clk);
    stop = 1'b1; @(negedge clk); @(negedge clk);
    chk("R9 flag re-raised", done, 1);
    stop = 1'b0; @(negedge clk);
    chk("R9 drop on stop release", done, 0);

    // flag event and clear pulse in the same cycle
    send(8'h5A);
    repeat (8) @(negedge clk);
    stop = 1'b1;
    wait_idle();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R10 set wins over clear", done, 1);
    stop = 1'b0;
    @(negedge clk);
    chk("R3 ready after stop release", ready, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule